// File: doc/BRIEF.md
# Two-Level Weighted Slave Arbiter

This arbiter guards one slave port of a bus matrix with several masters. Every master drives a request line and a one-cycle transfer-done strobe, and the arbiter answers with a registered, one-hot grant vector. The low-numbered masters form a fixed-priority class. The remaining masters form a weighted round-robin class, and they reach the slave only when no fixed-priority master asks for it. Address decoding, data steering and the bus protocol itself sit outside this block.

A round-robin master that holds the slave may complete a programmable number of back-to-back transfers before it yields. This weight is set per master. A fixed-priority master that is kept waiting by a round-robin owner is guaranteed service within a programmable number of cycles, once a per-slave enable for that bound is set. When the bound runs out, the round-robin owner is removed even if it still has weight left. A small write-only register port holds the weights, the wait bound and its enable. The values can be changed while traffic is running.

Top module: `slv_arb_2lvl`

## Requirements
- R1: `gnt` is driven from a register and has at most one bit set in any cycle. During reset and on the first cycle after reset it is all zero.
- R2: Whenever the slave is re-assigned, any fixed-priority request (masters 0 to N_FP-1) wins over every round-robin request. Among fixed-priority requesters the lowest index is granted, in the cycle after the decision.
- R3: A fixed-priority master keeps its grant until its `done` bit is sampled high. In the following cycle the slave is re-assigned among the current requests.
- R4: Round-robin masters are searched in rising index order, wrapping around. After a round-robin master yields or is removed, the search starts at the master after it.
- R5: Weight field value W lets a round-robin master complete W+1 consecutive transfers (range 1 to 32, reset field 0 = 1 transfer). On the (W+1)-th `done` it yields. The weight is taken from the register when the grant is made.
- R6: A round-robin master with weight left that still requests keeps the slave after each `done`, even while fixed-priority masters are waiting, until the wait bound expires.
- R7: Latency field value L (reset 7) bounds the wait of a fixed-priority master at L+1 cycles. If a fixed-priority request is first sampled in cycle c while a round-robin master is granted, and the request is held, the fixed-priority grant is visible in cycle c+L+1. A round-robin master is never removed in favour of another round-robin master.
- R8: When the wait-bound enable bit is 0, a round-robin owner is never removed before its `done`. The enable resets to 1.
- R9: If `done` of the owner is sampled while no master requests, `gnt` is zero in the next cycle.
- R10: A register write takes `cfg_wdat` when `cfg_wr` is high. `cfg_sel` = k (0 to N_RR-1) selects the weight of round-robin master N_FP+k (bits 4:0). `cfg_sel` = N_RR selects the latency field (bits 2:0). `cfg_sel` = N_RR+1 selects the enable (bit 0). New values apply to later decisions.
- R11: When the wait bound expires in the same cycle as the owner's final weighted `done`, exactly one re-assignment happens: the fixed-priority master is granted, and the round-robin search later resumes after the removed master.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | N_FP+N_RR | Request per master, fixed-priority masters in the low bits |
| done | input | N_FP+N_RR | Transfer-complete strobe per master |
| gnt | output | N_FP+N_RR | Registered one-hot grant |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | $clog2(N_RR+2) | Register select |
| cfg_wdat | input | 5 | Register write data |

## Verification
Two events can fall on the same clock edge: the wait-bound timer expiring, and the round-robin owner finishing its last weighted transfer. The bench sets the latency field to 0 and a weight of one transfer. It then raises a fixed-priority request in the same cycle as the owner's `done`. It judges the outcome by a single switch of the grant to the fixed-priority master, and by the next round-robin grant going to the master after the removed one. A cycle-by-cycle behavioural model covers random mixes of both events in every wait setting.

// File: rtl/slv_arb_pkg.sv
// Shared field widths, reset values and helpers for the two-level arbiter.
// Assumes weight and latency fields encode "value plus one".
package slv_arb_pkg;
    localparam int WGT_W = 5;
    localparam int LAT_W = 3;

    typedef logic [WGT_W-1:0] wgt_t;
    typedef logic [LAT_W-1:0] lat_t;

    localparam wgt_t WGT_RST = '0;   // one transfer
    localparam lat_t LAT_RST = '1;   // eight cycles
    localparam logic EN_RST  = 1'b1;
endpackage

// File: rtl/slv_arb_cfg.sv
// Write-only configuration store: one weight per round-robin master,
// the latency bound and its enable. Assumes cfg_sel values above
// N_RR+1 are never written (they are ignored).
module slv_arb_cfg
    import slv_arb_pkg::*;
#(
    parameter int N_RR  = 4,
    parameter int SEL_W = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr,
    input  logic [SEL_W-1:0]            sel,
    input  logic [WGT_W-1:0]            wdat,
    output logic [N_RR-1:0][WGT_W-1:0]  wgt,
    output lat_t                        lat,
    output logic                        lat_en
);
    localparam logic [SEL_W-1:0] SEL_LAT = SEL_W'(N_RR);
    localparam logic [SEL_W-1:0] SEL_EN  = SEL_W'(N_RR + 1);

    logic unused_hi_bits;
    assign unused_hi_bits = ^wdat[WGT_W-1:1];

    // One weight register per round-robin master.
    for (genvar k = 0; k < N_RR; k++) begin : g_wgt
        wgt_t w_q;
        // Load weight k on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                w_q <= WGT_RST;
            else if (wr && sel == SEL_W'(k))
                w_q <= wdat;
        end
        assign wgt[k] = w_q;
    end

    // Latency bound and enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat    <= LAT_RST;
            lat_en <= EN_RST;
        end else if (wr) begin
            if (sel == SEL_LAT) lat    <= wdat[LAT_W-1:0];
            if (sel == SEL_EN)  lat_en <= wdat[0];
        end
    end
endmodule

// File: rtl/slv_arb_rrpick.sv
// Rotating-priority finder: returns the first set request at or after
// 'start', wrapping around. Purely combinational. Assumes start < N_RR.
module slv_arb_rrpick #(
    parameter int N_RR = 4,
    parameter int RR_W = 2
) (
    input  logic [N_RR-1:0] rq,
    input  logic [RR_W-1:0] start,
    output logic            hit,
    output logic [RR_W-1:0] idx
);
    // Scan from the farthest offset down so the nearest request wins.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int k = N_RR - 1; k >= 0; k--) begin
            int c;
            c = int'(start) + k;
            if (c >= N_RR) c = c - N_RR;
            if (rq[RR_W'(c)]) begin
                hit = 1'b1;
                idx = RR_W'(c);
            end
        end
    end
endmodule

// File: rtl/slv_arb_wait.sv
// Counts cycles a fixed-priority master waits behind a round-robin
// owner and flags expiry when the programmed bound is reached.
// Assumes 'clr' is raised on every re-assignment of the slave.
module slv_arb_wait
    import slv_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic clr,
    input  lat_t lat,
    output logic expire
);
    lat_t cnt_q;

    // Count consecutive waiting cycles of the current grant.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr || !active)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // Greater-or-equal so a lowered bound still fires at once.
    assign expire = active && (cnt_q >= lat);
endmodule

// File: rtl/slv_arb_2lvl.sv
// Two-level slave arbiter. Masters 0..N_FP-1 have fixed priority (lowest
// index first). Masters N_FP.. share the slave by weighted round robin.
// Assumes a master that is granted keeps requesting until its done strobe;
// done of a non-owner is ignored.
module slv_arb_2lvl
    import slv_arb_pkg::*;
#(
    parameter  int N_FP  = 2,
    parameter  int N_RR  = 4,
    localparam int N_ALL = N_FP + N_RR,
    localparam int SEL_W = $clog2(N_RR + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_ALL-1:0] req,
    input  logic [N_ALL-1:0] done,
    output logic [N_ALL-1:0] gnt,
    input  logic             cfg_wr,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [4:0]       cfg_wdat
);
    localparam int OWN_W = $clog2(N_ALL);
    localparam int RR_W  = $clog2(N_RR);
    localparam int FP_W  = (N_FP > 1) ? $clog2(N_FP) : 1;

    logic [N_RR-1:0][WGT_W-1:0] wgt_all;
    lat_t                       lat_cfg;
    logic                       lat_en;

    logic [N_ALL-1:0] gnt_q, gnt_nx;
    logic             busy_q;
    logic [OWN_W-1:0] own_q, own_nx;
    logic [RR_W-1:0]  ptr_q, start_c, own_rr_idx, rr_idx;
    wgt_t             used_q, wlim_q;

    logic [N_FP-1:0]  fp_rq;
    logic [N_RR-1:0]  rr_rq;
    logic             fp_hit, rr_hit;
    logic [FP_W-1:0]  fp_idx;
    logic             own_rr, own_done, own_req, wgt_out;
    logic             release_c, active_c, expire_c, rearb_c, yield_rr;

    slv_arb_cfg #(.N_RR(N_RR), .SEL_W(SEL_W)) cfg_i (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .sel(cfg_sel), .wdat(cfg_wdat),
        .wgt(wgt_all), .lat(lat_cfg), .lat_en(lat_en)
    );

    assign fp_rq = req[N_FP-1:0];
    assign rr_rq = req[N_ALL-1:N_FP];

    // Lowest-index fixed-priority requester.
    always_comb begin
        fp_hit = 1'b0;
        fp_idx = '0;
        for (int k = N_FP - 1; k >= 0; k--) begin
            if (fp_rq[FP_W'(k)]) begin
                fp_hit = 1'b1;
                fp_idx = FP_W'(k);
            end
        end
    end

    // Owner status: class, completion and weight use.
    always_comb begin
        own_rr     = busy_q && (own_q >= OWN_W'(N_FP));
        own_rr_idx = RR_W'(own_q - OWN_W'(N_FP));
        own_done   = busy_q && done[own_q];
        own_req    = req[own_q];
        wgt_out    = own_rr && own_done && (used_q == wlim_q);
        release_c  = own_done && (!own_rr || wgt_out || !own_req);
        active_c   = own_rr && fp_hit && lat_en;
    end

    slv_arb_wait wait_i (
        .clk(clk), .rst_n(rst_n), .active(active_c), .clr(rearb_c),
        .lat(lat_cfg), .expire(expire_c)
    );

    // Decide when to re-assign and where the round-robin search starts.
    always_comb begin
        rearb_c  = !busy_q || release_c || expire_c;
        yield_rr = own_rr && (release_c || expire_c);
        if (yield_rr)
            start_c = (own_rr_idx == RR_W'(N_RR - 1)) ? '0 : own_rr_idx + 1'b1;
        else
            start_c = ptr_q;
    end

    slv_arb_rrpick #(.N_RR(N_RR), .RR_W(RR_W)) pick_i (
        .rq(rr_rq), .start(start_c), .hit(rr_hit), .idx(rr_idx)
    );

    // Next owner and its one-hot grant.
    always_comb begin
        own_nx = fp_hit ? OWN_W'(fp_idx) : OWN_W'(rr_idx) + OWN_W'(N_FP);
        gnt_nx = '0;
        if (fp_hit || rr_hit) gnt_nx[own_nx] = 1'b1;
    end

    // Grant, owner, pointer and weight bookkeeping registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_q  <= '0;
            busy_q <= 1'b0;
            own_q  <= '0;
            ptr_q  <= '0;
            used_q <= '0;
            wlim_q <= '0;
        end else if (rearb_c) begin
            gnt_q  <= gnt_nx;
            busy_q <= fp_hit || rr_hit;
            own_q  <= own_nx;
            ptr_q  <= start_c;
            used_q <= '0;
            wlim_q <= fp_hit ? WGT_RST : wgt_all[rr_idx];
        end else if (own_rr && own_done) begin
            used_q <= used_q + 1'b1;
        end
    end

    assign gnt = gnt_q;
endmodule

// File: rtl/slv_arb_chk.sv
// Property checker for slv_arb_2lvl, attached by bind. Observes ports and
// the configured wait bound; holds no state the design relies on.
module slv_arb_chk #(
    parameter int N_FP = 2,
    parameter int N_RR = 4,
    localparam int N_ALL = N_FP + N_RR
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_ALL-1:0] req,
    input logic [N_ALL-1:0] done,
    input logic [N_ALL-1:0] gnt,
    input logic [2:0]       lat_cfg,
    input logic             lat_en
);
    logic [N_ALL-1:0] prev_q;
    logic [3:0]       wcnt_q;
    logic             waiting;

    assign waiting = (|gnt[N_ALL-1:N_FP]) && (|req[N_FP-1:0]) && lat_en;

    // Track waiting cycles spent behind the same round-robin grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            wcnt_q <= '0;
        end else begin
            prev_q <= gnt;
            if (!waiting)          wcnt_q <= '0;
            else if (gnt != prev_q) wcnt_q <= 4'd1;
            else                   wcnt_q <= wcnt_q + 4'd1;
        end
    end

    assert_gnt_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    assert_fp_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt == '0 && (|req[N_FP-1:0])) |=> (|gnt[N_FP-1:0]));

    assert_fp_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((|gnt[N_FP-1:0]) && !(|(gnt & done))) |=> $stable(gnt));

    // R7: without a waiting fixed-priority master no round-robin owner moves.
    assert_rr_no_rr_preempt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((|gnt[N_ALL-1:N_FP]) && !(|(gnt & done)) && !(|req[N_FP-1:0])) |=> $stable(gnt));

    assert_wait_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && gnt == prev_q) |-> (wcnt_q <= {1'b0, lat_cfg}));

    assert_bound_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((|gnt[N_ALL-1:N_FP]) && !lat_en && !(|(gnt & done))) |=> $stable(gnt));

    assert_idle_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(gnt & done)) && req == '0) |=> gnt == '0);
endmodule

bind slv_arb_2lvl slv_arb_chk #(.N_FP(N_FP), .N_RR(N_RR)) chk_i (
    .clk(clk), .rst_n(rst_n), .req(req), .done(done), .gnt(gnt),
    .lat_cfg(lat_cfg), .lat_en(lat_en)
);

// File: tb/slv_arb_2lvl_tb_top.sv
`timescale 1ns/1ps
// Bench: directed scenarios plus random traffic, compared every cycle
// against a behavioural reference model.
module slv_arb_2lvl_tb_top;
    localparam int N_FP = 2;
    localparam int N_RR = 4;
    localparam int N    = N_FP + N_RR;
    localparam int WD_LIM = 150000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic [N-1:0] done = '0;
    logic [N-1:0] gnt;
    logic         cfg_wr = 1'b0;
    logic [2:0]   cfg_sel = '0;
    logic [4:0]   cfg_wdat = '0;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    string cur_req = "R1";

    // reference model state
    int m_own, m_used, m_wlim, m_ptr, m_wc, m_lat, m_en;
    int m_wgt [N_RR];

    slv_arb_2lvl #(.N_FP(N_FP), .N_RR(N_RR)) dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .done(done), .gnt(gnt),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdat(cfg_wdat)
    );

    always #2 clk = ~clk;

    function automatic logic [N-1:0] own_vec(int o);
        logic [N-1:0] v;
        v = '0;
        if (o >= 0) v[o] = 1'b1;
        return v;
    endfunction

    // Behavioural reference: one arbitration decision per clock.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_own = -1; m_used = 0; m_wlim = 0; m_ptr = 0; m_wc = 0;
            m_lat = 7; m_en = 1;
            for (int k = 0; k < N_RR; k++) m_wgt[k] = 0;
        end else begin
            int fpl, nxt, start;
            bit isrr, odone, act, expd, wout, rel, re;
            fpl = -1;
            for (int k = N_FP - 1; k >= 0; k--) if (req[k]) fpl = k;
            isrr  = (m_own >= N_FP);
            odone = (m_own >= 0) && done[m_own];
            act   = isrr && (fpl >= 0) && (m_en != 0);
            expd  = act && (m_wc >= m_lat);
            wout  = isrr && odone && (m_used == m_wlim);
            rel   = odone && (!isrr || wout || !req[m_own]);
            re    = (m_own < 0) || rel || expd;
            start = m_ptr;
            if (isrr && (rel || expd)) start = (m_own - N_FP + 1) % N_RR;
            if (re) begin
                nxt = -1;
                if (fpl >= 0) nxt = fpl;
                else for (int s = 0; s < N_RR; s++)
                    if (nxt < 0 && req[N_FP + (start + s) % N_RR]) nxt = N_FP + (start + s) % N_RR;
                m_own = nxt; m_used = 0; m_wc = 0; m_ptr = start;
                m_wlim = (nxt >= N_FP) ? m_wgt[nxt - N_FP] : 0;
            end else begin
                if (isrr && odone) m_used++;
                m_wc = act ? m_wc + 1 : 0;
            end
            if (cfg_wr) begin
                if (cfg_sel < 3'(N_RR)) m_wgt[cfg_sel] = int'(cfg_wdat);
                else if (cfg_sel == 3'(N_RR)) m_lat = int'(cfg_wdat[2:0]);
                else if (cfg_sel == 3'(N_RR + 1)) m_en = int'(cfg_wdat[0]);
            end
        end
    end

    // Every-cycle comparison with the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            total++;
            if (gnt !== own_vec(m_own)) begin
                bad++;
                $display("FAIL %s model: actual=%b expected=%b", cur_req, gnt, own_vec(m_own));
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles == WD_LIM) begin
            bad++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic cyc(input logic [N-1:0] r, input logic [N-1:0] d);
        req = r; done = d;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] s, input logic [4:0] v);
        cfg_wr = 1'b1; cfg_sel = s; cfg_wdat = v;
        cyc('0, '0);
        cfg_wr = 1'b0;
    endtask

    task automatic expect_gnt(input logic [N-1:0] exp_v, input string tag);
        total++;
        if (gnt !== exp_v) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", tag, gnt, exp_v);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        expect_gnt('0, "R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        expect_gnt('0, "R1 after reset");

        // R2 / R3: fixed-priority order and hold
        cur_req = "R2";
        cyc(6'b000110, '0);        expect_gnt(6'b000010, "R2 fp over rr");
        cur_req = "R3";
        cyc(6'b000111, '0);        expect_gnt(6'b000010, "R3 fp holds");
        cyc(6'b000111, 6'b000010); expect_gnt(6'b000001, "R2 lowest fp");
        cyc(6'b000100, 6'b000001); expect_gnt(6'b000100, "R3 rearb after done");
        cur_req = "R5";
        cyc(6'b000100, 6'b000100); expect_gnt(6'b000100, "R5 default weight one");
        cur_req = "R9";
        cyc('0, 6'b000100);        expect_gnt('0, "R9 idle drop");

        // R10 / R5 / R4: weight of master 3 set to 3 transfers
        cur_req = "R10";
        wr(3'd1, 5'd2);
        cyc(6'b001100, '0);        expect_gnt(6'b001000, "R4 start after yielder");
        cur_req = "R5";
        cyc(6'b001100, 6'b001000);
        cyc(6'b001100, 6'b001000); expect_gnt(6'b001000, "R5 weight remaining");
        cyc(6'b001100, 6'b001000); expect_gnt(6'b000100, "R5 weight used R10");
        cur_req = "R4";
        cyc(6'b001100, 6'b000100); expect_gnt(6'b001000, "R4 rotate");
        cyc('0, 6'b001000);        expect_gnt('0, "R9 release");

        // R6 / R7: latency field 2 -> fixed-priority grant after 3 cycles
        cur_req = "R7";
        wr(3'd4, 5'd2);
        cyc(6'b010000, '0);        expect_gnt(6'b010000, "R7 rr owner");
        cyc(6'b010001, '0);
        cyc(6'b010001, '0);        expect_gnt(6'b010000, "R6 rr holds while fp waits");
        cyc(6'b010001, '0);        expect_gnt(6'b000001, "R7 preempt at bound");
        cur_req = "R4";
        cyc(6'b110000, 6'b000001); expect_gnt(6'b100000, "R4 resume after preempted");
        cyc(6'b110000, 6'b100000); expect_gnt(6'b010000, "R4 wrap");
        cyc('0, 6'b010000);        expect_gnt('0, "R9 release");

        // R8: bound disabled
        cur_req = "R8";
        wr(3'd5, 5'd0);
        cyc(6'b100000, '0);
        for (int i = 0; i < 12; i++) cyc(6'b100001, '0);
        expect_gnt(6'b100000, "R8 no preempt when disabled");
        cyc(6'b000001, 6'b100000); expect_gnt(6'b000001, "R8 fp after done");
        cyc('0, 6'b000001);
        wr(3'd5, 5'd1);

        // R11: expiry and final weighted done in the same cycle
        cur_req = "R11";
        wr(3'd4, 5'd0);
        cyc(6'b000100, '0);        expect_gnt(6'b000100, "R11 rr owner");
        cyc(6'b000101, 6'b000100); expect_gnt(6'b000001, "R11 single switch to fp");
        cyc(6'b001100, 6'b000001); expect_gnt(6'b001000, "R11 pointer past removed");
        cyc('0, 6'b001000);

        // Random traffic per latency setting
        cur_req = "R7";
        for (int b = 0; b < 8; b++) begin
            cyc('0, '1); cyc('0, '1);
            wr(3'd4, 5'(7 - b));
            for (int i = 0; i < 400; i++) begin
                logic [N-1:0] r, d;
                r = N'($urandom);
                d = N'($urandom & $urandom);
                if ($urandom % 16 == 0) begin
                    cfg_wr = 1'b1;
                    cfg_sel = ($urandom % 5 == 4) ? 3'd5 : 3'($urandom % 4);
                    cfg_wdat = 5'($urandom % 4);
                end
                cyc(r, d);
                cfg_wr = 1'b0;
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule